// File: doc/BRIEF.md
# Bus Watchpoint Comparator

This block sits beside a CPU memory bus and watches every access. When an access hits the programmed target, the block produces a one-clock match pulse. An access hits when its address equals the target address exactly and its data passes the programmed data test. On instances that have the size option, the access must also be of the selected size. The pulse is meant to feed trigger logic elsewhere.

Software loads four configuration registers through a simple write port:

- the target address;
- the compare data;
- a per-bit data mask;
- a control word.

The control word selects one of two data tests. In the equality test, every enabled bit must agree with the compare data. In the difference test, at least one enabled bit must disagree.

Two elaboration flags set what an instance supports. One flag enables the difference test. The other enables the access-size qualification and byte-lane-aware data compare.

The bus carries 16-bit addresses and 16-bit data. Byte lanes are big-endian: an even address uses `bus_data[15:8]` and an odd address uses `bus_data[7:0]`.

Top module: `bus_watchpoint`

## Requirements
- R1: A match requires `bus_addr` to equal the target address exactly. A word access at target minus one, which touches the target byte, never matches.
- R2: With the control difference bit at 0, a match requires `((bus_data ^ compare_data) & mask) == 0`. Bit positions whose mask bit is 0 are ignored.
- R3: With the difference bit at 0 and the mask all zero, the match depends on the address and size only. Any data value matches.
- R4: With the difference bit at 1 (instances with HAS_DIFF=1), a match requires the address to hit and at least one bit position with its mask bit set to differ from the compare data.
- R5: With the difference bit at 1 and the mask all zero, the block never matches, even at the target address.
- R6: With the size-enable bit at 0, byte and word accesses to the target both match.
- R7: With the size-enable bit at 1 (instances with HAS_SIZE=1), the size-select bit picks the access type that can match. A value of 0 accepts only word accesses (`bus_byte`=0). A value of 1 accepts only byte accesses (`bus_byte`=1).
- R8: In HAS_SIZE=1 instances, a byte access compares only its own lane. An even address uses mask/data bits 15:8, and an odd address uses bits 7:0. Mask bits of the other lane are treated as 0.
- R9: In HAS_SIZE=0 instances, the data test always uses all 16 bits, whatever the access size. A byte access can therefore match when the other lane happens to hold the compare data.
- R10: `match_o` is registered. It is high for exactly the one clock that follows a rising edge at which a qualifying access with `bus_valid`=1 was sampled. It is low after any edge where `bus_valid` was 0.
- R11: Reset clears all registers, giving target address 0, compare data 0, mask 0 and control 0. A register write is used by an access sampled at the very next rising edge. `cfg_sel` codes are 0 address, 1 compare data, 2 mask and 3 control. Control bits are: bit0 difference, bit1 size-enable, bit2 size-select.
- R12: When HAS_DIFF=0, the difference bit reads as 0. When HAS_SIZE=0, the size-enable and size-select bits read as 0. Writing these bits then has no effect on matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| bus_valid | input | 1 | Bus access valid in this cycle |
| bus_addr | input | 16 | Bus access address |
| bus_data | input | 16 | Bus access data |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| match_o | output | 1 | Registered match pulse |

## Verification
An access presented before a rising edge is judged against the configuration held at that edge. Its match result appears on `match_o` just after the edge and lasts one clock.

A configuration write also lands on a rising edge, so an access placed in the following cycle already sees the new value. The bench drives every input on the falling edge and samples `match_o` on the next falling edge, exactly one rising edge later. An idle cycle directly after a match confirms that the pulse has dropped.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int WP_AW     = 16;
    localparam int WP_DW     = 16;
    localparam int WP_LANE_W = WP_DW / 2;
    localparam int WP_SEL_W  = 2;

    typedef logic [WP_AW-1:0] wp_addr_t;
    typedef logic [WP_DW-1:0] wp_data_t;

    typedef enum logic [WP_SEL_W-1:0] {
        WP_REG_ADDR = 2'd0,
        WP_REG_DATA = 2'd1,
        WP_REG_MASK = 2'd2,
        WP_REG_CTRL = 2'd3
    } wp_reg_e;

    localparam int WP_CTRL_DIFF  = 0;
    localparam int WP_CTRL_SZEN  = 1;
    localparam int WP_CTRL_SZSEL = 2;

    typedef struct packed {
        wp_addr_t addr;
        wp_data_t data;
        wp_data_t mask;
        logic     diff;
        logic     size_en;
        logic     size_sel;
    } wp_cfg_t;

    // Lanes a given access actually touches (big-endian: even -> high lane).
    function automatic wp_data_t wp_lane_mask(input logic is_byte, input logic odd);
        wp_data_t m;
        if (!is_byte)
            m = '1;
        else if (odd)
            m = {{WP_LANE_W{1'b0}}, {WP_LANE_W{1'b1}}};
        else
            m = {{WP_LANE_W{1'b1}}, {WP_LANE_W{1'b0}}};
        return m;
    endfunction

endpackage

// File: rtl/wp_cfg_regs.sv
module wp_cfg_regs
    import wp_pkg::*;
#(
    parameter bit HAS_DIFF = 1'b1,
    parameter bit HAS_SIZE = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [WP_SEL_W-1:0] sel,
    input  wp_data_t            wdata,
    output wp_cfg_t             cfg_o
);

    wp_cfg_t cfg_q;
    wire unused_ctrl_hi = ^wdata[WP_DW-1:WP_CTRL_SZSEL+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            unique case (wp_reg_e'(sel))
                WP_REG_ADDR: cfg_q.addr <= wp_addr_t'(wdata);
                WP_REG_DATA: cfg_q.data <= wdata;
                WP_REG_MASK: cfg_q.mask <= wdata;
                WP_REG_CTRL: begin
                    cfg_q.diff     <= HAS_DIFF ? wdata[WP_CTRL_DIFF]  : 1'b0;
                    cfg_q.size_en  <= HAS_SIZE ? wdata[WP_CTRL_SZEN]  : 1'b0;
                    cfg_q.size_sel <= HAS_SIZE ? wdata[WP_CTRL_SZSEL] : 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/wp_addr_qual.sv
module wp_addr_qual
    import wp_pkg::*;
(
    input  wp_addr_t tgt_addr,
    input  wp_addr_t bus_addr,
    input  logic     is_byte,
    input  logic     size_en,
    input  logic     size_sel,
    output logic     hit_o
);

    logic addr_eq;
    logic size_ok;

    always_comb begin
        addr_eq = (bus_addr == tgt_addr);
        size_ok = !size_en || (is_byte == size_sel);
        hit_o   = addr_eq && size_ok;
    end

endmodule

// File: rtl/wp_data_cmp.sv
module wp_data_cmp
    import wp_pkg::*;
#(
    parameter bit HAS_SIZE = 1'b1
) (
    input  wp_data_t cmp_data,
    input  wp_data_t mask,
    input  logic     diff,
    input  wp_data_t bus_data,
    input  logic     addr_lsb,
    input  logic     is_byte,
    output logic     hit_o
);

    wp_data_t eff_mask;
    wp_data_t delta;

    generate
        if (HAS_SIZE) begin : g_lane
            assign eff_mask = mask & wp_lane_mask(is_byte, addr_lsb);
        end else begin : g_full
            wire unused_lane = addr_lsb ^ is_byte;
            assign eff_mask = mask;
        end
    endgenerate

    always_comb begin
        delta = (bus_data ^ cmp_data) & eff_mask;
        hit_o = diff ? (|delta) : ~(|delta);
    end

endmodule

// File: rtl/bus_watchpoint.sv
module bus_watchpoint
    import wp_pkg::*;
#(
    parameter bit HAS_DIFF = 1'b1,
    parameter bit HAS_SIZE = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [WP_SEL_W-1:0] cfg_sel,
    input  logic [WP_DW-1:0]    cfg_wdata,
    input  logic                bus_valid,
    input  logic [WP_AW-1:0]    bus_addr,
    input  logic [WP_DW-1:0]    bus_data,
    input  logic                bus_byte,
    output logic                match_o
);

    wp_cfg_t cfg_q;
    logic    addr_hit;
    logic    data_hit;
    logic    match_q;

    wp_cfg_regs #(.HAS_DIFF(HAS_DIFF), .HAS_SIZE(HAS_SIZE)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg_o (cfg_q)
    );

    wp_addr_qual u_addr (
        .tgt_addr (cfg_q.addr),
        .bus_addr (bus_addr),
        .is_byte  (bus_byte),
        .size_en  (cfg_q.size_en),
        .size_sel (cfg_q.size_sel),
        .hit_o    (addr_hit)
    );

    wp_data_cmp #(.HAS_SIZE(HAS_SIZE)) u_data (
        .cmp_data (cfg_q.data),
        .mask     (cfg_q.mask),
        .diff     (cfg_q.diff),
        .bus_data (bus_data),
        .addr_lsb (bus_addr[0]),
        .is_byte  (bus_byte),
        .hit_o    (data_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) match_q <= 1'b0;
        else     match_q <= bus_valid && addr_hit && data_hit;
    end

    assign match_o = match_q;

endmodule

// File: rtl/bus_watchpoint_chk.sv
module bus_watchpoint_chk
    import wp_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     bus_valid,
    input wp_addr_t bus_addr,
    input wp_data_t bus_data,
    input logic     bus_byte,
    input wp_cfg_t  cfg,
    input logic     match_o
);

    p_valid_gate_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_valid) |-> !match_o);

    p_exact_addr_r1: assert property (@(posedge clk) disable iff (rst)
        match_o |-> $past(bus_addr == cfg.addr));

    p_eq_word_r2: assert property (@(posedge clk) disable iff (rst)
        (match_o && $past(!cfg.diff && !bus_byte))
            |-> $past(((bus_data ^ cfg.data) & cfg.mask) == '0));

    p_diff_zero_mask_r5: assert property (@(posedge clk) disable iff (rst)
        match_o |-> !$past(cfg.diff && (cfg.mask == '0)));

    p_size_sel_r7: assert property (@(posedge clk) disable iff (rst)
        (match_o && $past(cfg.size_en)) |-> $past(bus_byte == cfg.size_sel));

endmodule

bind bus_watchpoint bus_watchpoint_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_data  (bus_data),
    .bus_byte  (bus_byte),
    .cfg       (cfg_q),
    .match_o   (match_o)
);

// File: tb/bus_watchpoint_tb.sv
`timescale 1ns/1ps
module bus_watchpoint_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        bus_valid = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_data = '0;
    logic        bus_byte = 1'b0;
    logic        match_a;
    logic        match_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // model of the programmed registers
    logic [15:0] m_addr = '0, m_data = '0, m_mask = '0;
    logic        m_diff = 0, m_sen = 0, m_ssel = 0;

    always #2.5 clk = ~clk;

    bus_watchpoint #(.HAS_DIFF(1'b1), .HAS_SIZE(1'b1)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_byte(bus_byte), .match_o(match_a));

    bus_watchpoint #(.HAS_DIFF(1'b0), .HAS_SIZE(1'b0)) u_dut_b (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_byte(bus_byte), .match_o(match_b));

    function automatic bit ref_match(bit hd, bit hs, bit v, logic [15:0] a,
                                     logic [15:0] d, bit byt);
        bit          df, se, ss;
        logic [15:0] m, x;
        df = hd & m_diff;
        se = hs & m_sen;
        ss = hs & m_ssel;
        if (!v) return 1'b0;
        if (a != m_addr) return 1'b0;
        if (se && (byt != ss)) return 1'b0;
        m = m_mask;
        if (hs && byt) m = m & (a[0] ? 16'h00FF : 16'hFF00);
        x = (d ^ m_data) & m;
        return df ? (x != 0) : (x == 0);
    endfunction

    task automatic check(string req, bit got, bit exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic cfg_write(logic [1:0] sel, logic [15:0] val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            2'd0: m_addr = val;
            2'd1: m_data = val;
            2'd2: m_mask = val;
            default: begin m_diff = val[0]; m_sen = val[1]; m_ssel = val[2]; end
        endcase
    endtask

    // drive one access, sample one rising edge later, check both instances
    task automatic access(string req, bit v, logic [15:0] a, logic [15:0] d, bit byt);
        bit ea, eb;
        ea = ref_match(1'b1, 1'b1, v, a, d, byt);
        eb = ref_match(1'b0, 1'b0, v, a, d, byt);
        bus_valid = v; bus_addr = a; bus_data = d; bus_byte = byt;
        @(negedge clk);
        bus_valid = 1'b0;
        check({req, " u_dut"}, match_a, ea);
        check({req, " u_dut_b"}, match_b, eb);
    endtask

    task automatic access_exp(string req, bit v, logic [15:0] a, logic [15:0] d, bit byt,
                              bit ea, bit eb);
        bus_valid = v; bus_addr = a; bus_data = d; bus_byte = byt;
        @(negedge clk);
        bus_valid = 1'b0;
        check({req, " u_dut"}, match_a, ea);
        check({req, " u_dut_b"}, match_b, eb);
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R11 reset a", match_a, 1'b0);
        check("R11 reset b", match_b, 1'b0);

        // R11: zero config = equality, empty mask, target 0
        access_exp("R11 zero cfg", 1'b1, 16'h0000, 16'hBEEF, 1'b1, 1'b1, 1'b1);
        access_exp("R10 pulse drops", 1'b0, 16'h0000, 16'hBEEF, 1'b1, 1'b0, 1'b0);
        access_exp("R10 valid low", 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0);

        // R1 / R3 with mask clear; write followed directly by access (R11)
        cfg_write(2'd0, 16'h1234);
        access_exp("R11 write next clock", 1'b1, 16'h1234, 16'h5555, 1'b0, 1'b1, 1'b1);
        access_exp("R3 any data", 1'b1, 16'h1234, 16'h0F0F, 1'b0, 1'b1, 1'b1);
        access_exp("R1 word at target-1", 1'b1, 16'h1233, 16'h0F0F, 1'b0, 1'b0, 1'b0);
        access_exp("R1 target+1", 1'b1, 16'h1235, 16'h0F0F, 1'b1, 1'b0, 1'b0);

        // R2 masked equality
        cfg_write(2'd1, 16'hA5C3);
        cfg_write(2'd2, 16'hFF0F);
        access_exp("R2 masked bits ignored", 1'b1, 16'h1234, 16'hA5F3, 1'b0, 1'b1, 1'b1);
        access_exp("R2 enabled bit differs", 1'b1, 16'h1234, 16'hA4C3, 1'b0, 1'b0, 1'b0);

        // R4 difference test; R12 u_dut_b ignores it
        cfg_write(2'd3, 16'h0001);
        access_exp("R4 no enabled diff", 1'b1, 16'h1234, 16'hA5F3, 1'b0, 1'b0, 1'b1);
        access_exp("R4 enabled diff R12", 1'b1, 16'h1234, 16'hA4C3, 1'b0, 1'b1, 1'b0);
        access_exp("R4 wrong address", 1'b1, 16'h1236, 16'hA4C3, 1'b0, 1'b0, 1'b0);

        // R5 difference with empty mask
        cfg_write(2'd2, 16'h0000);
        access_exp("R5 empty mask diff", 1'b1, 16'h1234, 16'h0000, 1'b0, 1'b0, 1'b1);
        access_exp("R5 empty mask diff byte", 1'b1, 16'h1234, 16'hFFFF, 1'b1, 1'b0, 1'b1);

        // R6 size check off
        cfg_write(2'd3, 16'h0000);
        access_exp("R6 word", 1'b1, 16'h1234, 16'h1111, 1'b0, 1'b1, 1'b1);
        access_exp("R6 byte", 1'b1, 16'h1234, 16'h2222, 1'b1, 1'b1, 1'b1);

        // R7 size qualification; R12 u_dut_b ignores it
        cfg_write(2'd3, 16'h0002);
        access_exp("R7 word-only word", 1'b1, 16'h1234, 16'h0, 1'b0, 1'b1, 1'b1);
        access_exp("R7 word-only byte R12", 1'b1, 16'h1234, 16'h0, 1'b1, 1'b0, 1'b1);
        cfg_write(2'd3, 16'h0006);
        access_exp("R7 byte-only byte", 1'b1, 16'h1234, 16'h0, 1'b1, 1'b1, 1'b1);
        access_exp("R7 byte-only word R12", 1'b1, 16'h1234, 16'h0, 1'b0, 1'b0, 1'b1);

        // R8 / R9 byte lanes
        cfg_write(2'd3, 16'h0000);
        cfg_write(2'd2, 16'hFFFF);
        access_exp("R8 even lane", 1'b1, 16'h1234, 16'hA500, 1'b1, 1'b1, 1'b0);
        access_exp("R9 other lane equal", 1'b1, 16'h1234, 16'hA5C3, 1'b1, 1'b1, 1'b1);
        access_exp("R8 even lane differs", 1'b1, 16'h1234, 16'hA4C3, 1'b1, 1'b0, 1'b0);
        cfg_write(2'd0, 16'h1235);
        access_exp("R8 odd lane", 1'b1, 16'h1235, 16'h00C3, 1'b1, 1'b1, 1'b0);
        access_exp("R9 word full compare", 1'b1, 16'h1235, 16'h00C3, 1'b0, 1'b0, 1'b0);

        // random mix against the bench model (R2 R4 R7 R8 R9 R10)
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            logic [15:0] a, d;
            r = $urandom;
            if (r[3:0] == 4'd0) begin
                cfg_write(2'd0, 16'($urandom));
            end else if (r[3:0] == 4'd1) begin
                cfg_write(2'd1, 16'($urandom));
            end else if (r[3:0] == 4'd2) begin
                case (r[5:4])
                    2'd0: cfg_write(2'd2, 16'h0000);
                    2'd1: cfg_write(2'd2, 16'hFFFF);
                    default: cfg_write(2'd2, 16'($urandom));
                endcase
            end else if (r[3:0] == 4'd3) begin
                cfg_write(2'd3, {13'd0, 3'($urandom)});
            end
            case (r[7:6])
                2'd0: a = m_addr;
                2'd1: a = m_addr - 16'd1;
                2'd2: a = m_addr + 16'd1;
                default: a = (r[8]) ? m_addr : 16'($urandom);
            endcase
            case (r[10:9])
                2'd0: d = m_data;
                2'd1: d = m_data ^ (16'd1 << r[14:11]);
                default: d = 16'($urandom);
            endcase
            access("R2 R4 R7 R8 R9 R10 random", (r[19:16] != 4'd0), a, d, r[15]);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule